// File: doc/BRIEF.md
# Event Counter with Edge Input

An 8-bit up-counter that sits at one location of a register file. Software can load it or read it at any time. In pin mode it counts falling edges on an asynchronous event input. In tick mode it counts internal instruction-cycle tick strobes.

The event pin passes through a two-flop synchroniser, followed by a falling-edge detector. The counter wraps from 255 to 0 and does not stop at zero. A register write has priority: when a write and a counted event fall in the same clock cycle, the counter takes the written value and the event is lost.

Top module: `evt_ctr`

## Requirements
- R1: In pin mode (`src_sel_i` = 0), each high-to-low transition of `evt_pin_i` adds one to the count. The new value is visible on `cnt_o` after the third rising clock edge that follows the pin falling.
- R2: The count wraps from 8'hFF to 8'h00 and keeps counting up.
- R3: A cycle with `wr_en_i` = 1 loads `wr_data_i` into the counter at that clock edge.
- R4: When a write and a counted event (pin edge or tick) arrive at the same edge, the counter holds the written value and the event is discarded.
- R5: In tick mode (`src_sel_i` = 1), the count goes up by one at each clock edge where `tick_i` = 1. Falling edges on `evt_pin_i` leave the count unchanged.
- R6: In pin mode, `tick_i` has no effect on the count.
- R7: Reset (`rst_ni` = 0) clears the count to 0 and clears the edge-detector history. A pin held low through reset and afterwards is not counted.
- R8: A pin that stays low for two clock cycles and then high for two clock cycles is counted once for every falling edge.
- R9: `cnt_o` always shows the current counter value, with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_pin_i | input | 1 | Asynchronous external event pin |
| tick_i | input | 1 | Instruction-cycle tick strobe |
| src_sel_i | input | 1 | Count source: 0 = pin falling edges, 1 = tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| cnt_o | output | 8 | Current counter value |

## Verification
The bench drives a write onto the exact edge at which a synchronised pin edge, or a tick, would increment the counter. A design that let the event win would read one above the written value. It holds the pin low across reset and release; a detector whose history comes out of reset as 1 would count a phantom edge. It toggles the pin in tick mode and pulses the tick in pin mode, which catches a source mux that ORs the two sources. It also walks the count through 8'hFF, which catches a counter that saturates or stops at zero.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  typedef enum logic {
    SRC_PIN  = 1'b0,
    SRC_TICK = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/evt_fall_det.sv
module evt_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  // history resets to 0 so a low level after reset is never an edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign fall_o = prev_q & ~lvl_i;

  assert_no_back_to_back_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_data_i;  // write beats event
    else if (inc_i)   cnt_q <= cnt_q + ONE; // natural wrap

  assign cnt_o = cnt_q;

  assert_write_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_o == $past(wr_data_i));
  assert_step_wraps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && inc_i && cnt_o == '1) |=> cnt_o == '0);
  assert_step_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && inc_i) |=> cnt_o == $past(cnt_o) + ONE);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/evt_ctr.sv
module evt_ctr
  import evt_ctr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_pin_i,
  input  logic             tick_i,
  input  logic             src_sel_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] cnt_o
);
  cnt_src_e src;
  logic     pin_sync;
  logic     pin_fall;
  logic     inc;

  assign src = cnt_src_e'(src_sel_i);

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (evt_pin_i),
    .q_o   (pin_sync)
  );

  evt_fall_det u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_sync),
    .fall_o(pin_fall)
  );

  always_comb begin
    unique case (src)
      SRC_TICK: inc = tick_i;
      default:  inc = pin_fall;
    endcase
  end

  evt_count_core #(.WIDTH(WIDTH)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .cnt_o    (cnt_o)
  );

  assert_tick_mode_ignores_pin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i && !tick_i && !wr_en_i) |=> $stable(cnt_o));
  assert_pin_mode_ignores_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_sel_i && !pin_fall && !wr_en_i) |=> $stable(cnt_o));
endmodule

// File: tb/evt_ctr_tb_top.sv
module evt_ctr_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 13;
  // op: 0 write, 1 pin fall, 2 tick pulse, 3 set mode (data[0]); {op, data, expected}
  localparam logic [17:0] VEC [NV] = '{
    {2'd3, 8'h00, 8'h00},
    {2'd0, 8'h10, 8'h10},
    {2'd1, 8'h00, 8'h11},
    {2'd1, 8'h00, 8'h12},
    {2'd2, 8'h00, 8'h12},
    {2'd0, 8'hFE, 8'hFE},
    {2'd1, 8'h00, 8'hFF},
    {2'd1, 8'h00, 8'h00},
    {2'd1, 8'h00, 8'h01},
    {2'd3, 8'h01, 8'h01},
    {2'd2, 8'h00, 8'h02},
    {2'd1, 8'h00, 8'h02},
    {2'd2, 8'h00, 8'h03}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       tick = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdat = 8'h00;
  logic [7:0] cnt;
  int         errors = 0;
  int         checks = 0;

  always #(CLK_P/2) clk = ~clk;

  evt_ctr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_pin_i(pin), .tick_i(tick),
    .src_sel_i(sel), .wr_en_i(wr), .wr_data_i(wdat), .cnt_o(cnt)
  );

  task automatic chk(input logic [7:0] exp, input string tag);
    checks++;
    if (cnt !== exp) begin
      errors++;
      $display("FAIL %s: cnt=%02h expected=%02h", tag, cnt, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdat = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_fall(input int lo, input int hi);
    @(negedge clk); pin = 1'b0;
    repeat (lo) @(negedge clk);
    pin = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: cnt=%02h expected=done", cnt);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(8'h00, "R7 reset value");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(8'h00, "R9 idle after reset");

    // table walk: R1 R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: begin do_write(VEC[i][15:8]); chk(VEC[i][7:0], "R3 write"); end
        2'd1: begin do_fall(3, 3); chk(VEC[i][7:0], sel ? "R5 pin ignored" : "R1/R2 pin edge"); end
        2'd2: begin do_tick(); chk(VEC[i][7:0], sel ? "R5 tick" : "R6 tick ignored"); end
        default: begin @(negedge clk); sel = VEC[i][8]; repeat (2) @(negedge clk); chk(VEC[i][7:0], "R9 mode change"); end
      endcase
    end

    // R4 tick mode: write and tick on the same edge
    @(negedge clk); tick = 1'b1; wr = 1'b1; wdat = 8'h77;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    chk(8'h77, "R4 write vs tick");

    // R4 pin mode: write lands on the increment edge
    @(negedge clk); sel = 1'b0;
    repeat (3) @(negedge clk);
    pin = 1'b0;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; wdat = 8'h40;
    @(negedge clk); wr = 1'b0;
    chk(8'h40, "R4 write vs pin edge");
    pin = 1'b1;
    repeat (4) @(negedge clk);
    chk(8'h40, "R4 edge discarded");

    // R1 latency: not yet after two edges, visible after the third
    pin = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(8'h40, "R1 not before third edge");
    @(negedge clk);
    chk(8'h41, "R1 after third edge");
    pin = 1'b1;
    repeat (3) @(negedge clk);

    // R8 minimum phases: 5 edges, 2 low / 2 high
    for (int k = 0; k < 5; k++) do_fall(2, 2);
    repeat (2) @(negedge clk);
    chk(8'h46, "R8 min phase burst");

    // R7 reset with pin held low, then release
    pin = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(8'h00, "R7 reset clears");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(8'h00, "R7 no phantom edge");
    pin = 1'b1;
    repeat (3) @(negedge clk);
    do_fall(2, 3);
    chk(8'h01, "R7 counts after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule